// File: doc/BRIEF.md
# Serial ADC Read Sequencer

This block is the host side of a link to a 10-bit converter that returns its results over a serial line. While its run enable is high it repeats one access after another. Each access pulls chip select low and waits out the converter's chip-select deglitch time. It then issues exactly ten evenly spaced I/O clock pulses, collecting one data bit per pulse with the most significant bit first, and raises chip select again. After that it keeps the converter idle for the full conversion time before the next access may begin. Every pulse width and wait is a cycle count. Each count is derived at elaboration from the system clock frequency and from time values given in nanoseconds or hertz.

The converter sends back the result of the conversion that the previous access started. The sequencer therefore raises its result-valid strobe only when the word being read came from a conversion that ran to completion. The first access after reset carries no such word. Neither does the access that follows an abort. An abort request that arrives early enough in the conversion wait ends the conversion: chip select goes low at once and a new access starts. A request that arrives at any other time is ignored.

The states are IDLE, CS_SETUP, SHIFT, CS_HOLD and CONV_WAIT. The transitions are:
- IDLE to CS_SETUP when run is high.
- CS_SETUP to SHIFT once the deglitch count has elapsed.
- SHIFT to CS_HOLD after the low half of the tenth I/O clock period.
- CS_HOLD to CONV_WAIT once the deglitch count has elapsed.
- CONV_WAIT to IDLE when the conversion count runs out.
- CONV_WAIT to CS_SETUP on an accepted abort.

Top module: `sadc_reader`

## Requirements
- R1: While reset is high, and in the cycle after it, cs_n is 1, io_clk is 0, result_valid is 0 and result is 0.
- R2: Every level of cs_n lasts at least HOLD cycles, where HOLD = ceil(CS_HOLD_NS × SYS_CLK_HZ / 1e9). The first io_clk rise of an access comes at least HOLD cycles after cs_n falls.
- R3: Each access gives exactly ten io_clk pulses. Every high phase lasts HALF cycles and successive rises are 2×HALF cycles apart, where HALF = ceil(SYS_CLK_HZ / (2 × IOCLK_MAX_HZ)).
- R4: io_clk is 0 whenever cs_n is 1.
- R5: sdi is sampled on the last system cycle of each io_clk high phase. The first sample becomes result bit 9, the most significant bit, and the last becomes bit 0. The codes 0x3FF and 0x000 pass through unchanged.
- R6: result_valid is a one-cycle pulse in the cycle right after the tenth io_clk fall. It fires only when the access reads a completed conversion, which is never the first access after reset or the access after an abort. result changes only together with result_valid.
- R7: An access that is not an abort begins only after CONV = ceil(CONV_NS × SYS_CLK_HZ / 1e9) cycles have passed since the tenth io_clk fall.
- R8: abort_req high in a CONV_WAIT cycle that lies fewer than ABORT_NS worth of cycles after the tenth fall, with a margin of HALF+1, is accepted. cs_n is then 0 in the next cycle, and the result of that conversion is never strobed.
- R9: abort_req in any other state, or later in CONV_WAIT, has no effect. cs_n stays 1 in the next cycle and the next access strobes its result.
- R10: With run high, chip select stays high for exactly CONV+1 cycles between accesses. With run low, an access in progress completes, and after that cs_n stays 1 and no access starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Continuous-run enable |
| abort_req | input | 1 | Request to end the conversion in progress |
| sdi | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Chip select, active low |
| io_clk | output | 1 | Converter I/O clock, idles low |
| result | output | RES_W | Last strobed conversion code |
| result_valid | output | 1 | One-cycle strobe for a new result |

## Verification
The assertions assume that sdi settles well inside each io_clk high phase. They also assume that abort_req is a synchronous level, sampled only on system clock edges. The bench's converter model changes sdi only on the sample that follows an io_clk fall, so each bit is stable for the full high phase. The bench changes abort_req and run only on falling system clock edges. The abort pulses are placed at fixed offsets from the chip-select rise, so that one falls inside the acceptance window, one falls in CS_HOLD and one falls late in CONV_WAIT.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_CS_SETUP  = 3'd1,
        ST_SHIFT     = 3'd2,
        ST_CS_HOLD   = 3'd3,
        ST_CONV_WAIT = 3'd4
    } sadc_state_e;

    function automatic longint unsigned ceil_div(input longint unsigned num,
                                                 input longint unsigned den);
        return (num + den - 64'd1) / den;
    endfunction

endpackage

// File: rtl/sadc_downcnt.sv
module sadc_downcnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic         zero
);

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/sadc_shiftin.sv
module sadc_shiftin #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         sdi,
    input  logic         commit,
    input  logic         keep,
    output logic [W-1:0] data,
    output logic         valid
);

    logic [W-1:0] sr_q;
    logic [W-1:0] next_word;

    assign next_word = {sr_q[W-2:0], sdi};

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q  <= '0;
            data  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (shift_en) sr_q <= next_word;
            if (commit && keep) begin
                data  <= next_word;
                valid <= 1'b1;
            end
        end
    end

    // R6: the strobe never lasts two cycles
    a_r6_valid_single: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

endmodule

// File: rtl/sadc_reader.sv
module sadc_reader #(
    parameter longint unsigned SYS_CLK_HZ   = 125_000_000,
    parameter longint unsigned IOCLK_MAX_HZ = 2_100_000,
    parameter longint unsigned CONV_NS      = 21_000,
    parameter longint unsigned CS_HOLD_NS   = 1_425,
    parameter longint unsigned ABORT_NS     = 9_000,
    parameter int              RES_W        = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             abort_req,
    input  logic             sdi,
    output logic             cs_n,
    output logic             io_clk,
    output logic [RES_W-1:0] result,
    output logic             result_valid
);
    import sadc_pkg::*;

    localparam int HALF_CYC  = int'(ceil_div(SYS_CLK_HZ, 2 * IOCLK_MAX_HZ));
    localparam int HOLD_CYC  = int'(ceil_div(CS_HOLD_NS * SYS_CLK_HZ, 64'd1_000_000_000));
    localparam int CONV_CYC  = int'(ceil_div(CONV_NS * SYS_CLK_HZ, 64'd1_000_000_000));
    localparam int ABORT_CYC = int'(ceil_div(ABORT_NS * SYS_CLK_HZ, 64'd1_000_000_000));
    localparam int ABORT_LIM = ABORT_CYC - HALF_CYC - 1;
    localparam int ABORT_MIN = CONV_CYC - 1 - ABORT_LIM;
    localparam int CW        = $clog2(CONV_CYC + 1);
    localparam int HW        = (HALF_CYC > 1) ? $clog2(HALF_CYC + 1) : 1;
    localparam int BITW      = $clog2(RES_W + 1);

    sadc_state_e     state_q, state_d;
    logic            cs_n_q, phase_q, have_q;
    logic [BITW-1:0] bit_q;

    logic            wt_load, wt_zero;
    logic [CW-1:0]   wt_val, wt_cnt;
    logic            ph_load, ph_zero;
    logic [HW-1:0]   ph_cnt;
    logic            shift_en, commit, abort_ok, last_low;

    sadc_downcnt #(.W(CW)) u_wait (
        .clk(clk), .rst(rst), .load(wt_load), .load_val(wt_val),
        .cnt(wt_cnt), .zero(wt_zero)
    );

    sadc_downcnt #(.W(HW)) u_phase (
        .clk(clk), .rst(rst), .load(ph_load), .load_val(HW'(HALF_CYC - 1)),
        .cnt(ph_cnt), .zero(ph_zero)
    );

    sadc_shiftin #(.W(RES_W)) u_shift (
        .clk(clk), .rst(rst), .shift_en(shift_en), .sdi(sdi),
        .commit(commit), .keep(have_q), .data(result), .valid(result_valid)
    );

    assign abort_ok = (state_q == ST_CONV_WAIT) && abort_req && (wt_cnt > CW'(ABORT_MIN));
    assign last_low = (state_q == ST_SHIFT) && ph_zero && !phase_q && (bit_q == BITW'(RES_W));
    assign shift_en = (state_q == ST_SHIFT) && ph_zero && phase_q;
    assign commit   = shift_en && (bit_q == BITW'(RES_W - 1));

    // next state and counter loads
    always_comb begin
        state_d = state_q;
        wt_load = 1'b0;
        wt_val  = '0;
        ph_load = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (run) begin
                    state_d = ST_CS_SETUP;
                    wt_load = 1'b1;
                    wt_val  = CW'(HOLD_CYC - 1);
                end
            end
            ST_CS_SETUP: begin
                if (wt_zero) begin
                    state_d = ST_SHIFT;
                    ph_load = 1'b1;
                end
            end
            ST_SHIFT: begin
                if (last_low) begin
                    state_d = ST_CS_HOLD;
                    wt_load = 1'b1;
                    wt_val  = CW'(HOLD_CYC - 1);
                end else if (ph_zero) begin
                    ph_load = 1'b1;
                end
            end
            ST_CS_HOLD: begin
                if (wt_zero) begin
                    state_d = ST_CONV_WAIT;
                    wt_load = 1'b1;
                    wt_val  = CW'(CONV_CYC - HOLD_CYC - 1);
                end
            end
            ST_CONV_WAIT: begin
                if (abort_ok) begin
                    state_d = ST_CS_SETUP;
                    wt_load = 1'b1;
                    wt_val  = CW'(HOLD_CYC - 1);
                end else if (wt_zero) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // registered outputs and frame bookkeeping
    always_ff @(posedge clk) begin
        if (rst) begin
            cs_n_q  <= 1'b1;
            phase_q <= 1'b0;
            bit_q   <= '0;
            have_q  <= 1'b0;
        end else begin
            cs_n_q <= (state_d == ST_IDLE) || (state_d == ST_CS_HOLD) ||
                      (state_d == ST_CONV_WAIT);
            if (state_q == ST_CS_SETUP) begin
                bit_q   <= '0;
                phase_q <= (state_d == ST_SHIFT);
            end else if (state_q == ST_SHIFT) begin
                if (ph_zero) begin
                    if (phase_q) begin
                        phase_q <= 1'b0;
                        bit_q   <= bit_q + 1'b1;
                    end else begin
                        phase_q <= (bit_q != BITW'(RES_W));
                    end
                end
            end else begin
                phase_q <= 1'b0;
            end
            if (commit)
                have_q <= 1'b0;
            else if ((state_q == ST_CONV_WAIT) && (state_d == ST_IDLE))
                have_q <= 1'b1;
        end
    end

    assign cs_n   = cs_n_q;
    assign io_clk = phase_q;

    // checker state: cycles spent at the present chip-select level
    logic [CW-1:0] cs_age_q;
    always_ff @(posedge clk) begin
        if (rst)
            cs_age_q <= CW'(HOLD_CYC);
        else if (cs_n_q != ((state_d == ST_IDLE) || (state_d == ST_CS_HOLD) ||
                            (state_d == ST_CONV_WAIT)))
            cs_age_q <= '0;
        else if (cs_age_q < CW'(HOLD_CYC))
            cs_age_q <= cs_age_q + 1'b1;
    end

    // R2: a chip-select level is never shorter than the deglitch time
    a_r2_cs_level_held: assert property (@(posedge clk) disable iff (rst)
        !$stable(cs_n_q) |-> ($past(cs_age_q) >= CW'(HOLD_CYC - 1)));

    // R4: the I/O clock rests low while deselected
    a_r4_clk_low_when_idle: assert property (@(posedge clk) disable iff (rst)
        cs_n_q |-> !phase_q);

    // R6: the held result moves only with its strobe
    a_r6_result_held: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (result_valid || $stable(result)));

    // R8: the only way from the conversion wait back to selection is an abort
    a_r8_abort_path: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_CS_SETUP) && ($past(state_q) == ST_CONV_WAIT)) |-> $past(abort_req));

    // R7: a normal access starts only from IDLE
    a_r7_start_from_idle: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n_q) |-> ($past(state_q) == ST_IDLE || $past(state_q) == ST_CONV_WAIT));

endmodule

// File: tb/sadc_reader_bench.sv
module sadc_reader_bench;

    localparam int HALF  = 4;
    localparam int HOLD  = 6;
    localparam int CONV  = 40;
    localparam int ABORT = 17;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       run = 1'b0;
    logic       abort_req = 1'b0;
    logic       sdi = 1'b0;
    logic       cs_n, io_clk, result_valid;
    logic [9:0] result;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    sadc_reader #(
        .SYS_CLK_HZ(125_000_000), .IOCLK_MAX_HZ(15_625_000),
        .CONV_NS(320), .CS_HOLD_NS(48), .ABORT_NS(136), .RES_W(10)
    ) u_sadc_reader (
        .clk(clk), .rst(rst), .run(run), .abort_req(abort_req), .sdi(sdi),
        .cs_n(cs_n), .io_clk(io_clk), .result(result), .result_valid(result_valid)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [9:0] code_at(input int i);
        case (i % 6)
            0: return 10'h3FF;
            1: return 10'h000;
            2: return 10'h2A5;
            3: return 10'h15A;
            4: return 10'h200;
            default: return 10'h001;
        endcase
    endfunction

    // converter model and per-cycle reference
    bit         cs_last, ck_last, busy, fresh, fresh_start, abort_seen;
    int         lvl_len, falls, rises, since_cs, since_rise, hi_len, age, ci;
    int         n_valid, n_cs_fall;
    logic [9:0] done_code, samp_code, out_sr, last_result;

    always @(negedge clk) begin
        if (rst) begin
            chk(cs_n == 1'b1, "R1 cs_n in reset", cs_n, 1);
            chk(io_clk == 1'b0, "R1 io_clk in reset", io_clk, 0);
            chk(result_valid == 1'b0, "R1 valid in reset", result_valid, 0);
            chk(result == 10'd0, "R1 result in reset", result, 0);
            cs_last = 1'b1; ck_last = 1'b0; busy = 1'b0; fresh = 1'b0;
            fresh_start = 1'b0; lvl_len = HOLD; falls = 0; rises = 0;
            since_cs = 0; since_rise = 0; hi_len = 0; age = 0; ci = 0;
            done_code = '0; samp_code = '0; out_sr = '0; last_result = '0;
            n_valid = 0; n_cs_fall = 0;
        end else begin
            bit exp_v;
            exp_v = 1'b0;
            if (busy) begin
                age++;
                if (age >= CONV) begin
                    done_code = samp_code;
                    fresh = 1'b1;
                    busy = 1'b0;
                end
            end
            since_cs++;
            since_rise++;
            chk(!(cs_n && io_clk), "R4 clock low while deselected", io_clk, 0);
            if (cs_n != cs_last) begin
                chk(lvl_len >= HOLD, "R2 chip-select level length", lvl_len, HOLD);
                lvl_len = 1;
                if (!cs_n) begin
                    n_cs_fall++;
                    if (busy) begin
                        chk(abort_seen && age < ABORT, "R7 access during conversion", age, CONV);
                        busy = 1'b0;
                    end
                    abort_seen = 1'b0;
                    out_sr = done_code;
                    fresh_start = fresh;
                    fresh = 1'b0;
                    falls = 0; rises = 0; since_cs = 0;
                    sdi = out_sr[9];
                end else begin
                    chk(falls == 10, "R3 ten clocks per access", falls, 10);
                end
            end else begin
                lvl_len++;
            end
            if (io_clk && !ck_last) begin
                if (rises == 0) chk(since_cs >= HOLD, "R2 select to first clock", since_cs, HOLD);
                else            chk(since_rise == 2*HALF, "R3 clock period", since_rise, 2*HALF);
                rises++;
                since_rise = 0;
                hi_len = 1;
            end else if (io_clk) begin
                hi_len++;
            end
            if (!io_clk && ck_last) begin
                chk(hi_len == HALF, "R3 high phase width", hi_len, HALF);
                falls++;
                if (falls < 10) sdi = out_sr[9 - falls];
                else begin
                    busy = 1'b1; age = 0;
                    samp_code = code_at(ci); ci++;
                    exp_v = fresh_start;
                end
            end
            chk(result_valid == exp_v, "R6 strobe timing", result_valid, exp_v);
            if (exp_v) begin
                chk(result == out_sr, "R5 captured word", result, out_sr);
                n_valid++;
            end
            if (!result_valid)
                chk(result == last_result, "R6 result held", result, last_result);
            last_result = result;
            cs_last = cs_n;
            ck_last = io_clk;
        end
    end

    task automatic wait_cs(input logic v);
        do @(negedge clk); while (cs_n !== v);
    endtask

    task automatic frame_end();
        wait_cs(1'b0);
        wait_cs(1'b1);
    endtask

    // pulse abort n samples after the chip-select rise sample
    task automatic abort_after_rise(input int n, input logic exp_cs, input string tag);
        frame_end();
        repeat (n) @(negedge clk);
        abort_req = 1'b1;
        abort_seen = 1'b1;
        @(negedge clk);
        chk(cs_n == exp_cs, tag, cs_n, exp_cs);
        abort_req = 1'b0;
    endtask

    initial begin
        int gap, base_v, base_f;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cs_n == 1'b1 && result_valid == 1'b0, "R1 state after reset", cs_n, 1);
        repeat (20) @(negedge clk);
        chk(cs_n == 1'b1, "R10 idle without run", cs_n, 1);

        run = 1'b1;
        frame_end();
        chk(n_valid == 0, "R6 no strobe on first access", n_valid, 0);
        gap = 0;
        do begin @(negedge clk); gap++; end while (cs_n);
        chk(gap == CONV + 1, "R10 back-to-back gap", gap, CONV + 1);
        repeat (3) frame_end();
        chk(n_valid == 3, "R5 strobes on completed conversions", n_valid, 3);

        abort_after_rise(6, 1'b0, "R8 abort accepted");
        base_v = n_valid;
        wait_cs(1'b1);
        chk(n_valid == base_v, "R8 aborted result discarded", n_valid, base_v);
        frame_end();
        chk(n_valid == base_v + 1, "R8 strobe resumes", n_valid, base_v + 1);

        abort_after_rise(3, 1'b1, "R9 abort during hold ignored");
        abort_after_rise(20, 1'b1, "R9 late abort ignored");
        base_v = n_valid;
        frame_end();
        chk(n_valid == base_v + 1, "R9 result kept after ignored abort", n_valid, base_v + 1);

        wait_cs(1'b0);
        run = 1'b0;
        wait_cs(1'b1);
        repeat (CONV + 10) @(negedge clk);
        base_f = n_cs_fall;
        abort_req = 1'b1;
        @(negedge clk);
        chk(cs_n == 1'b1, "R9 abort in idle ignored", cs_n, 1);
        abort_req = 1'b0;
        repeat (200) @(negedge clk);
        chk(n_cs_fall == base_f && cs_n == 1'b1, "R10 stays idle after run low", n_cs_fall, base_f);

        run = 1'b1;
        repeat (2) frame_end();
        run = 1'b0;
        repeat (CONV + 10) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog R10 run never ended actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule